// File: doc/BRIEF.md
# Single-Precision to Signed Integer Converter

This block turns a 32-bit IEEE-754 single-precision operand into a 32-bit two's-complement integer. A 2-bit mode input picks one of four rounding rules. A per-operation chop request forces rounding toward zero for that operand only, whatever the mode input holds.

Each operand arrives with a valid strobe. The result appears two clock cycles later with its own valid strobe, an inexact flag and an invalid flag. The pipeline never stalls and accepts one operand per cycle.

Subnormal operands and signed zeros are handled as ordinary values whose magnitude is below one. NaN, infinity and any value that falls outside the signed 32-bit range after rounding all produce a fixed integer-indefinite code.

Top module: `f2i_convert`

## Requirements
- R1: While reset is held and in the cycles after it is released, `out_valid` is 0 until an operand has been accepted.
- R2: Mode 2'b00 is nearest-even. The result is the integer closest to the operand. When the operand lies exactly halfway between two integers, the even one is returned (2.5 gives 2, 3.5 gives 4, 0.5 gives 0, -2.5 gives -2).
- R3: An operand that is already an integer is returned exactly with `out_inexact` = 0, in every mode (100.0 gives 100, -7.0 gives -7).
- R4: Mode 2'b01 rounds toward minus infinity. The result is the greatest integer not above the operand (2.5 gives 2, -2.5 gives -3, -0.5 gives -1).
- R5: Mode 2'b10 rounds toward plus infinity. The result is the least integer not below the operand (2.5 gives 3, -2.5 gives -2, 0.5 gives 1).
- R6: Mode 2'b11 rounds toward zero. The result is the integer of largest magnitude not exceeding the operand's magnitude (-1.75 gives -1, 2.5 gives 2).
- R7: When `in_chop` is 1, the operand is rounded toward zero whatever `in_rmode` holds.
- R8: A NaN, an infinity, or a value whose rounded result lies outside [-2^31, 2^31-1] gives `out_result` = 32'h8000_0000 with `out_invalid` = 1 and `out_inexact` = 0. An operand of exactly -2^31 is valid and gives 32'h8000_0000 with both flags at 0.
- R9: A nonzero operand of magnitude below one, including a subnormal, gives 0. The exceptions are the direction-matching directed mode, which gives +1 (mode 2'b10, positive operand) or -1 (mode 2'b01, negative operand), and nearest-even above one half. Signed zeros give 0 exactly.
- R10: `out_valid` and the output fields for an operand appear exactly two rising edges after the edge that accepts it. Operands can be presented on consecutive cycles.
- R11: `out_inexact` is 1 exactly when a valid result differs from the operand's exact value (1.25 in nearest-even gives 1 with `out_inexact` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 32 | Single-precision operand |
| in_rmode | input | 2 | Rounding mode: 00 nearest-even, 01 down, 10 up, 11 toward zero |
| in_chop | input | 1 | Force round toward zero for this operand |
| out_valid | output | 1 | Result strobe |
| out_result | output | 32 | Signed integer result |
| out_inexact | output | 1 | Result differs from the exact value |
| out_invalid | output | 1 | NaN, infinity or out-of-range operand |

## Verification
Every result is due on the second rising edge after the edge that accepts its operand. Neither the strobe nor any output field changes at the first edge. Each directed check drives its operand at a falling edge and waits two more falling edges. At that falling edge it samples the strobe and all three output fields together. The streaming scenario feeds four operands on consecutive cycles and checks each result at the falling edge two cycles after its operand, which confirms that results neither overlap nor shift out of order.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  // Rounding mode encoding seen on the in_rmode port
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
  import f2i_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [EXP_W+MAN_W:0]   in_operand,
  input  logic [1:0]             in_rmode,
  input  logic                   in_chop,
  output logic                   s1_valid,
  output logic                   s1_sign,
  output logic [INT_W-1:0]       s1_mag,
  output logic                   s1_guard,
  output logic                   s1_sticky,
  output rmode_e                 s1_mode,
  output logic                   s1_special
);

  localparam int FLT_W = 1 + EXP_W + MAN_W;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int SH0   = INT_W - MAN_W;
  localparam int WIDE  = 2 * INT_W;
  localparam int SH_W  = $clog2(WIDE);
  localparam int UE_W  = EXP_W + 2;

  logic [EXP_W-1:0]       exp_f;
  logic [MAN_W-1:0]       frac_f;
  logic signed [UE_W-1:0] ue;
  logic [SH_W-1:0]        shamt;
  logic [WIDE-1:0]        wide;

  logic                   n_sign;
  logic [INT_W-1:0]       n_mag;
  logic                   n_guard;
  logic                   n_sticky;
  logic                   n_special;
  rmode_e                 n_mode;

  assign exp_f  = in_operand[FLT_W-2:MAN_W];
  assign frac_f = in_operand[MAN_W-1:0];
  assign ue     = $signed({2'b00, exp_f}) - $signed(UE_W'(BIAS));
  assign shamt  = SH_W'(ue + $signed(UE_W'(SH0)));

  // Next-state: align the significand onto a fixed point with INT_W
  // integer bits and INT_W fraction bits, then split off guard/sticky.
  always_comb begin
    n_sign    = in_operand[FLT_W-1];
    n_mag     = '0;
    n_guard   = 1'b0;
    n_sticky  = 1'b0;
    n_special = 1'b0;
    wide      = '0;
    n_mode    = in_chop ? RM_ZERO : rmode_e'(in_rmode);
    if (exp_f == {EXP_W{1'b1}}) begin
      n_special = 1'b1;
    end else if (exp_f == '0) begin
      n_sticky = |frac_f;
    end else if (ue >= INT_W) begin
      n_special = 1'b1;
    end else if (ue >= 0) begin
      wide     = {{(WIDE-MAN_W-1){1'b0}}, 1'b1, frac_f} << shamt;
      n_mag    = wide[WIDE-1:INT_W];
      n_guard  = wide[INT_W-1];
      n_sticky = |wide[INT_W-2:0];
    end else if (ue == -1) begin
      n_guard  = 1'b1;
      n_sticky = |frac_f;
    end else begin
      n_sticky = 1'b1;
    end
  end

  // Stage-1 register, data loaded only on an accepted operand
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid   <= 1'b0;
      s1_sign    <= 1'b0;
      s1_mag     <= '0;
      s1_guard   <= 1'b0;
      s1_sticky  <= 1'b0;
      s1_mode    <= RM_NEAR;
      s1_special <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_sign    <= n_sign;
        s1_mag     <= n_mag;
        s1_guard   <= n_guard;
        s1_sticky  <= n_sticky;
        s1_mode    <= n_mode;
        s1_special <= n_special;
      end
    end
  end

  // R9: a zero-exponent operand never carries integer bits or a guard bit
  a_r9_subnormal_below_half: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && exp_f == '0) |=> (s1_mag == '0 && !s1_guard && !s1_special));

  // R7: a chop request always reaches the rounding stage as toward-zero
  a_r7_chop_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_chop) |=> (s1_mode == RM_ZERO));

endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  logic             s1_sign,
  input  logic [INT_W-1:0] s1_mag,
  input  logic             s1_guard,
  input  logic             s1_sticky,
  input  rmode_e           s1_mode,
  input  logic             s1_special,
  output logic             out_valid,
  output logic [INT_W-1:0] out_result,
  output logic             out_inexact,
  output logic             out_invalid
);

  localparam logic [INT_W:0]   POS_LIM = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0]   NEG_LIM = {2'b01, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] INDEF   = {1'b1, {(INT_W-1){1'b0}}};

  logic             lost;
  logic             inc;
  logic [INT_W:0]   mag_r;
  logic             over;
  logic [INT_W-1:0] n_result;
  logic             n_inexact;
  logic             n_invalid;

  // Next-state: rounding increment, range check, sign application
  always_comb begin
    lost = s1_guard | s1_sticky;
    unique case (s1_mode)
      RM_NEAR: inc = s1_guard & (s1_sticky | s1_mag[0]);
      RM_DOWN: inc = s1_sign & lost;
      RM_UP:   inc = ~s1_sign & lost;
      default: inc = 1'b0;
    endcase
    mag_r = {1'b0, s1_mag} + {{INT_W{1'b0}}, inc};
    over  = s1_special | (mag_r > (s1_sign ? NEG_LIM : POS_LIM));
    if (over) begin
      n_result  = INDEF;
      n_inexact = 1'b0;
      n_invalid = 1'b1;
    end else begin
      n_result  = s1_sign ? (~mag_r[INT_W-1:0] + 1'b1) : mag_r[INT_W-1:0];
      n_inexact = lost;
      n_invalid = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_inexact <= 1'b0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_result  <= n_result;
        out_inexact <= n_inexact;
        out_invalid <= n_invalid;
      end
    end
  end

  // R3: no lost fraction bits means an exact, unflagged result
  a_r3_exact_unflagged: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_guard && !s1_sticky) |=> !out_inexact);

  // R6: toward-zero never grows a positive in-range magnitude
  a_r6_chop_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_mode == RM_ZERO && !s1_sign && !s1_special && !s1_mag[INT_W-1])
    |=> (out_result == $past(s1_mag)));

  // R11: lost bits on a safely in-range magnitude always raise inexact
  a_r11_lost_bits_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_special && (s1_guard || s1_sticky) && s1_mag[INT_W-1:INT_W-2] == 2'b00)
    |=> (out_inexact && !out_invalid));

endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
  import f2i_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [EXP_W+MAN_W:0] in_operand,
  input  logic [1:0]           in_rmode,
  input  logic                 in_chop,
  output logic                 out_valid,
  output logic [INT_W-1:0]     out_result,
  output logic                 out_inexact,
  output logic                 out_invalid
);

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;

  logic             s1_valid;
  logic             s1_sign;
  logic [INT_W-1:0] s1_mag;
  logic             s1_guard;
  logic             s1_sticky;
  rmode_e           s1_mode;
  logic             s1_special;

  // Reset asserts asynchronously, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  f2i_unpack #(
    .EXP_W (EXP_W),
    .MAN_W (MAN_W),
    .INT_W (INT_W)
  ) u_unpack (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .in_valid   (in_valid),
    .in_operand (in_operand),
    .in_rmode   (in_rmode),
    .in_chop    (in_chop),
    .s1_valid   (s1_valid),
    .s1_sign    (s1_sign),
    .s1_mag     (s1_mag),
    .s1_guard   (s1_guard),
    .s1_sticky  (s1_sticky),
    .s1_mode    (s1_mode),
    .s1_special (s1_special)
  );

  f2i_round #(
    .INT_W (INT_W)
  ) u_round (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .s1_valid    (s1_valid),
    .s1_sign     (s1_sign),
    .s1_mag      (s1_mag),
    .s1_guard    (s1_guard),
    .s1_sticky   (s1_sticky),
    .s1_mode     (s1_mode),
    .s1_special  (s1_special),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_inexact (out_inexact),
    .out_invalid (out_invalid)
  );

  // Cycles since reset, saturating; lets the latency check look back safely
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)        age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R10: result strobe trails the operand strobe by two edges
  a_r10_two_cycle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R8: an invalid result always carries the indefinite code, never inexact
  a_r8_indefinite: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_invalid) |-> (out_result == {1'b1, {(INT_W-1){1'b0}}} && !out_inexact));

  // R1: no result strobe in the first cycle out of reset
  a_r1_quiet_reset: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_q == 2'd0) |-> !out_valid);

endmodule

// File: tb/f2i_convert_tb.sv
`timescale 1ns/1ps
module f2i_convert_tb;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_operand;
  logic [1:0]  in_rmode;
  logic        in_chop;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_inexact;
  logic        out_invalid;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  f2i_convert u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_operand  (in_operand),
    .in_rmode    (in_rmode),
    .in_chop     (in_chop),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_inexact (out_inexact),
    .out_invalid (out_invalid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Drive one operand, wait for its result, check all fields
  task automatic conv(input string req, input logic [31:0] op, input logic [1:0] md,
                      input logic ch, input logic [31:0] er, input logic ex, input logic ei);
    @(negedge clk);
    in_valid = 1'b1; in_operand = op; in_rmode = md; in_chop = ch;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " early strobe (R10)"}, {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    chk({req, " strobe (R10)"}, {31'b0, out_valid}, 32'd1);
    chk({req, " result"},       out_result, er);
    chk({req, " inexact (R11)"}, {31'b0, out_inexact}, {31'b0, ex});
    chk({req, " invalid (R8)"},  {31'b0, out_invalid}, {31'b0, ei});
  endtask

  task automatic t_reset;
    in_valid = 1'b0; in_operand = '0; in_rmode = 2'b00; in_chop = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid after release", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_nearest;
    conv("R2 2.5 near",   32'h4020_0000, 2'b00, 1'b0, 32'd2,         1'b1, 1'b0);
    conv("R2 3.5 near",   32'h4060_0000, 2'b00, 1'b0, 32'd4,         1'b1, 1'b0);
    conv("R2 -2.5 near",  32'hC020_0000, 2'b00, 1'b0, 32'hFFFF_FFFE, 1'b1, 1'b0);
    conv("R2 1.75 near",  32'h3FE0_0000, 2'b00, 1'b0, 32'd2,         1'b1, 1'b0);
    conv("R11 1.25 near", 32'h3FA0_0000, 2'b00, 1'b0, 32'd1,         1'b1, 1'b0);
    conv("R2 0.5 near",   32'h3F00_0000, 2'b00, 1'b0, 32'd0,         1'b1, 1'b0);
  endtask

  task automatic t_down;
    conv("R4 2.5 down",  32'h4020_0000, 2'b01, 1'b0, 32'd2,         1'b1, 1'b0);
    conv("R4 -2.5 down", 32'hC020_0000, 2'b01, 1'b0, 32'hFFFF_FFFD, 1'b1, 1'b0);
    conv("R4 -0.5 down", 32'hBF00_0000, 2'b01, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0);
  endtask

  task automatic t_up;
    conv("R5 2.5 up",  32'h4020_0000, 2'b10, 1'b0, 32'd3,         1'b1, 1'b0);
    conv("R5 -2.5 up", 32'hC020_0000, 2'b10, 1'b0, 32'hFFFF_FFFE, 1'b1, 1'b0);
    conv("R5 0.5 up",  32'h3F00_0000, 2'b10, 1'b0, 32'd1,         1'b1, 1'b0);
  endtask

  task automatic t_zero;
    conv("R6 -1.75 zero", 32'hBFE0_0000, 2'b11, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0);
    conv("R6 2.5 zero",   32'h4020_0000, 2'b11, 1'b0, 32'd2,         1'b1, 1'b0);
  endtask

  task automatic t_exact;
    for (int m = 0; m < 4; m++) begin
      conv("R3 100.0", 32'h42C8_0000, 2'(m), 1'b0, 32'd100,       1'b0, 1'b0);
      conv("R3 -7.0",  32'hC0E0_0000, 2'(m), 1'b0, 32'hFFFF_FFF9, 1'b0, 1'b0);
    end
    conv("R3 large exact", 32'h4EFF_FFFF, 2'b10, 1'b0, 32'h7FFF_FF80, 1'b0, 1'b0);
  endtask

  task automatic t_chop;
    conv("R7 2.5 up chop",    32'h4020_0000, 2'b10, 1'b1, 32'd2,         1'b1, 1'b0);
    conv("R7 -2.5 down chop", 32'hC020_0000, 2'b01, 1'b1, 32'hFFFF_FFFE, 1'b1, 1'b0);
    conv("R7 1.75 near chop", 32'h3FE0_0000, 2'b00, 1'b1, 32'd1,         1'b1, 1'b0);
  endtask

  task automatic t_invalid;
    conv("R8 NaN",      32'h7FC0_0000, 2'b10, 1'b0, 32'h8000_0000, 1'b0, 1'b1);
    conv("R8 +inf",     32'h7F80_0000, 2'b00, 1'b0, 32'h8000_0000, 1'b0, 1'b1);
    conv("R8 -inf",     32'hFF80_0000, 2'b01, 1'b0, 32'h8000_0000, 1'b0, 1'b1);
    conv("R8 2^31",     32'h4F00_0000, 2'b11, 1'b0, 32'h8000_0000, 1'b0, 1'b1);
    conv("R8 -2^31",    32'hCF00_0000, 2'b00, 1'b0, 32'h8000_0000, 1'b0, 1'b0);
    conv("R8 -2^32",    32'hCF80_0000, 2'b00, 1'b0, 32'h8000_0000, 1'b0, 1'b1);
  endtask

  task automatic t_tiny;
    conv("R9 +sub near",  32'h0000_0001, 2'b00, 1'b0, 32'd0,         1'b1, 1'b0);
    conv("R9 +sub up",    32'h0000_0001, 2'b10, 1'b0, 32'd1,         1'b1, 1'b0);
    conv("R9 -sub down",  32'h8000_0001, 2'b01, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0);
    conv("R9 -sub zero",  32'h8000_0001, 2'b11, 1'b0, 32'd0,         1'b1, 1'b0);
    conv("R9 +0 up",      32'h0000_0000, 2'b10, 1'b0, 32'd0,         1'b0, 1'b0);
    conv("R9 -0 down",    32'h8000_0000, 2'b01, 1'b0, 32'd0,         1'b0, 1'b0);
    conv("R9 0.75 near",  32'h3F40_0000, 2'b00, 1'b0, 32'd1,         1'b1, 1'b0);
  endtask

  // Four operands on consecutive cycles
  task automatic t_stream;
    logic [31:0] ops [4];
    logic [1:0]  mds [4];
    logic [31:0] exr [4];
    ops[0] = 32'h4020_0000; mds[0] = 2'b10; exr[0] = 32'd3;
    ops[1] = 32'hC020_0000; mds[1] = 2'b01; exr[1] = 32'hFFFF_FFFD;
    ops[2] = 32'h42C8_0000; mds[2] = 2'b00; exr[2] = 32'd100;
    ops[3] = 32'h4060_0000; mds[3] = 2'b00; exr[3] = 32'd4;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (i >= 2 && i < 6) begin
        chk("R10 stream strobe", {31'b0, out_valid}, 32'd1);
        chk("R10 stream result", out_result, exr[i-2]);
      end
      if (i < 4) begin
        in_valid = 1'b1; in_operand = ops[i]; in_rmode = mds[i]; in_chop = 1'b0;
      end else begin
        in_valid = 1'b0;
      end
      if (i == 6) chk("R10 stream end", {31'b0, out_valid}, 32'd0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_nearest();
    t_down();
    t_up();
    t_zero();
    t_exact();
    t_chop();
    t_invalid();
    t_tiny();
    t_stream();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule